// File: doc/BRIEF.md
# Two-Stage Watchdog Escalator

This block watches a free-running 32-bit time base counter and raises an alarm in two stages when software stops servicing it. A two-bit period field in the control register picks one of four counter taps. Every 0-to-1 change of the chosen tap is a time-out, whether the counter's own increment or a software write to the counter causes it.

A pair of status bits drives a small state machine: enable-next (status bit 0) and interrupt-status (status bit 1). The state encoding is {interrupt-status, enable-next}, and there are four states:
- QUIET (00)
- ARMED (01)
- FIRED (10, reachable only through a software clear)
- ESCALATED (11)

A time-out takes one of three transitions, depending on the state it finds:
- **arm**: from QUIET or FIRED, it sets enable-next.
- **fire**: from ARMED, it sets interrupt-status and moves to ESCALATED.
- **escalate**: in ESCALATED, it stays put and issues a one-cycle reset request when the control register allows it.

The **clear** transition is a write-one-to-clear on the status register. The interrupt output follows interrupt-status, gated by the control interrupt enable and by either of two enable inputs.

Software services the watchdog by clearing enable-next. This leaves at least one and at most two full periods before the next time-out that counts.

Top module: `wdog_escalator`

## Requirements
- R1: While and right after synchronous reset `rst`, the time base, control register and status bits read 0, and `wd_irq` and `wd_rst_req` are 0.
- R2: The time base increases by one every clock. A write (`tb_we`) loads `tb_wdata`, which reads back on the next cycle, and counting then continues from there.
- R3: Control bits [1:0] select the tap: code 00 selects bit 12, 01 selects bit 8, 10 selects bit 6 and 11 selects bit 0. The resulting time-out spacings are 8192, 512, 128 and 2 clocks. A write to the control register never creates a time-out by itself.
- R4: A time base write that turns the selected bit from 0 to 1 is a time-out, the same as an increment.
- R5: A time-out in a state with enable-next = 0 (arm) only sets enable-next, visible on the cycle after the time-out.
- R6: A time-out in ARMED (fire) sets interrupt-status and leaves the machine in ESCALATED.
- R7: `wd_irq` = interrupt-status AND control bit 2 (interrupt enable) AND (`crit_en` OR `guest_en`).
- R8: A time-out in ESCALATED (escalate) makes `wd_rst_req` high for exactly the next cycle if control bit 3 (reset enable) was 1 in the time-out cycle. Otherwise `wd_rst_req` stays 0.
- R9: Writing `sts_we` with 1s in `sts_wdata` clears those status bits. A bit that a time-out sets in the same cycle stays set.
- R10: After software clears both status bits, interrupt-status is set again no sooner than one full period and no later than two full periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_we | input | 1 | Time base write strobe |
| tb_wdata | input | 32 | Time base write value |
| tb_q | output | 32 | Time base value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: [1:0] tap select, [2] interrupt enable, [3] reset enable |
| ctl_q | output | 4 | Control register value |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 2 | Write-one-to-clear mask: [0] enable-next, [1] interrupt-status |
| sts_q | output | 2 | Status bits: [0] enable-next, [1] interrupt-status |
| crit_en | input | 1 | Critical interrupt enable |
| guest_en | input | 1 | Guest state enable |
| wd_irq | output | 1 | Watchdog interrupt |
| wd_rst_req | output | 1 | One-cycle core reset request |

## Verification
The assertions assume that reset is held for at least one clock edge before any write strobe is used. They also assume that the write strobes and data stay stable across each rising edge. The bench changes every input shortly after the falling edge and holds reset for several cycles at the start of each phase. The property that forbids two time-outs in a row exempts cycles with a control write, because reloading the tap register may legally let a real edge of the new tap follow at once. The random phase writes the control register freely so that this case is reached.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int NTAP  = 4;
    localparam int SEL_W = $clog2(NTAP);
    localparam int CTL_W = SEL_W + 2;

    // status encoding {interrupt-status, enable-next}
    typedef enum logic [1:0] {
        S_QUIET = 2'b00,
        S_ARMED = 2'b01,
        S_FIRED = 2'b10,
        S_ESCAL = 2'b11
    } wd_state_e;

    typedef struct packed {
        logic             rst_en;
        logic             irq_en;
        logic [SEL_W-1:0] period;
    } wd_ctl_t;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
        else         q <= q + W'(1);
    end

    a_r2_count: assert property (@(posedge clk) disable iff (rst)
        !we |=> q == $past(q) + W'(1));
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(wdata));
endmodule

// File: rtl/wdog_edge.sv
module wdog_edge
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NTAP-1:0]  taps,
    input  logic [SEL_W-1:0] sel,
    input  logic             load,
    input  logic [SEL_W-1:0] load_sel,
    output logic             ev
);
    logic prev;

    // on a control write, remember the tap that will be selected next,
    // so switching taps cannot fabricate an edge
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= taps[load ? load_sel : sel];
    end

    assign ev = taps[sel] & ~prev;

    a_r3_single_edge: assert property (@(posedge clk) disable iff (rst)
        (ev && !load) |=> !ev);
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev,
    input  logic [1:0] clr,
    input  logic       rst_en,
    input  logic       irq_en,
    input  logic       crit_en,
    input  logic       guest_en,
    output logic [1:0] sts,
    output logic       irq,
    output logic       rst_req
);
    wd_state_e  st, st_nx;
    logic [1:0] setm;
    logic       esc;

    always_comb begin
        setm = 2'b00;
        esc  = 1'b0;
        if (ev) begin
            unique case (st)
                S_QUIET, S_FIRED: setm = 2'b01;  // arm
                S_ARMED:          setm = 2'b10;  // fire
                S_ESCAL:          esc  = 1'b1;   // escalate
            endcase
        end
        st_nx = wd_state_e'((st & ~clr) | setm);  // clear, set wins
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_QUIET;
            rst_req <= 1'b0;
        end else begin
            st      <= st_nx;
            rst_req <= esc & rst_en;
        end
    end

    always_comb begin
        sts = st;
        irq = st[1] & irq_en & (crit_en | guest_en);
    end

    a_r5_arm: assert property (@(posedge clk) disable iff (rst)
        (ev && st == S_QUIET && clr == 2'b00) |=> st == S_ARMED);
    a_r6_fire: assert property (@(posedge clk) disable iff (rst)
        (ev && st == S_ARMED && clr == 2'b00) |=> st == S_ESCAL);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev && st == S_ARMED) |=> st[1]);
    a_r8_from_escal: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(st == S_ESCAL && rst_en));
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdog_pkg::*;
#(
    parameter int TB_W = 32,
    parameter int TAP0 = 12,
    parameter int TAP1 = 8,
    parameter int TAP2 = 6,
    parameter int TAP3 = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_we,
    input  logic [TB_W-1:0]  tb_wdata,
    output logic [TB_W-1:0]  tb_q,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             sts_we,
    input  logic [1:0]       sts_wdata,
    output logic [1:0]       sts_q,
    input  logic             crit_en,
    input  logic             guest_en,
    output logic             wd_irq,
    output logic             wd_rst_req
);
    localparam int TAP_POS [NTAP] = '{TAP0, TAP1, TAP2, TAP3};

    wd_ctl_t         ctl;
    wd_ctl_t         ctl_in;
    logic [NTAP-1:0] tap_bits;
    logic            ev;

    assign ctl_in = wd_ctl_t'(ctl_wdata);

    always_ff @(posedge clk) begin
        if (rst)         ctl <= '0;
        else if (ctl_we) ctl <= ctl_in;
    end
    assign ctl_q = ctl;

    wdog_timebase #(.W(TB_W)) u_tb (
        .clk(clk), .rst(rst), .we(tb_we), .wdata(tb_wdata), .q(tb_q)
    );

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign tap_bits[g] = tb_q[TAP_POS[g]];
    end

    wdog_edge u_edge (
        .clk(clk), .rst(rst), .taps(tap_bits), .sel(ctl.period),
        .load(ctl_we), .load_sel(ctl_in.period), .ev(ev)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst(rst), .ev(ev),
        .clr(sts_we ? sts_wdata : 2'b00),
        .rst_en(ctl.rst_en), .irq_en(ctl.irq_en),
        .crit_en(crit_en), .guest_en(guest_en),
        .sts(sts_q), .irq(wd_irq), .rst_req(wd_rst_req)
    );

    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        wd_irq |-> (sts_q[1] && ctl.irq_en && (crit_en || guest_en)));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (sts_q == 2'b00 && !wd_rst_req && tb_q == '0));
endmodule

// File: tb/wdog_escalator_test.sv
module wdog_escalator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_we = 0, ctl_we = 0, sts_we = 0, crit_en = 0, guest_en = 0;
    logic [31:0] tb_wdata = 0;
    logic [3:0]  ctl_wdata = 0;
    logic [1:0]  sts_wdata = 0;
    logic [31:0] tb_q;
    logic [3:0]  ctl_q;
    logic [1:0]  sts_q;
    logic        wd_irq, wd_rst_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdog_escalator uut (
        .clk(clk), .rst(rst), .tb_we(tb_we), .tb_wdata(tb_wdata), .tb_q(tb_q),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_q(sts_q),
        .crit_en(crit_en), .guest_en(guest_en),
        .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
    );

    // behavioural reference model
    logic [31:0] m_tb = 0;
    logic [3:0]  m_ctl = 0;
    logic [1:0]  m_sts = 0;
    logic        m_prev = 0, m_rreq = 0;

    function automatic int tap(logic [1:0] p);
        case (p)
            2'd0: return 12;
            2'd1: return 8;
            2'd2: return 6;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic       hit;
        logic [1:0] setm;
        logic       req;
        if (rst) begin
            m_tb = 0; m_ctl = 0; m_sts = 0; m_prev = 0; m_rreq = 0;
        end else begin
            hit  = m_tb[tap(m_ctl[1:0])] && !m_prev;
            setm = 0;
            req  = 0;
            if (hit) begin
                if (!m_sts[0])      setm = 2'b01;
                else if (!m_sts[1]) setm = 2'b10;
                else                req  = m_ctl[3];
            end
            m_prev = m_tb[tap(ctl_we ? ctl_wdata[1:0] : m_ctl[1:0])];
            m_sts  = (m_sts & ~(sts_we ? sts_wdata : 2'b00)) | setm;
            m_rreq = req;
            m_tb   = tb_we ? tb_wdata : m_tb + 1;
            if (ctl_we) m_ctl = ctl_wdata;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 time base", tb_q, m_tb);
            chk("R3 control", {28'd0, ctl_q}, {28'd0, m_ctl});
            chk("R5 R6 R9 status", {30'd0, sts_q}, {30'd0, m_sts});
            chk("R7 interrupt", {31'd0, wd_irq},
                {31'd0, m_sts[1] & m_ctl[2] & (crit_en | guest_en)});
            chk("R8 reset request", {31'd0, wd_rst_req}, {31'd0, m_rreq});
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic do_reset();
        rst = 1; tb_we = 0; ctl_we = 0; sts_we = 0; crit_en = 0; guest_en = 0;
        tick(3);
        rst = 0;
    endtask

    task automatic write_tb(logic [31:0] v);
        tb_we = 1; tb_wdata = v; tick(1); tb_we = 0;
    endtask

    task automatic write_ctl(logic [3:0] v);
        ctl_we = 1; ctl_wdata = v; tick(1); ctl_we = 0;
    endtask

    task automatic clear_sts(logic [1:0] v);
        sts_we = 1; sts_wdata = v; tick(1); sts_we = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        int t;
        int t1;
        // R1 reset state
        tick(3);
        chk("R1 tb reset", tb_q, 0);
        chk("R1 sts reset", {30'd0, sts_q}, 0);
        chk("R1 ctl reset", {28'd0, ctl_q}, 0);
        chk("R1 outputs reset", {30'd0, wd_irq, wd_rst_req}, 0);
        rst = 0;

        // R2 load then count on
        tick(5);
        write_tb(32'h0000_0A00);
        chk("R2 load", tb_q, 32'h0000_0A00);
        tick(3);
        chk("R2 continue", tb_q, 32'h0000_0A03);

        // R4 software-written edge
        do_reset();
        tick(2);
        write_tb(32'h0000_1000);
        tick(1);
        chk("R4 written edge arms", {30'd0, sts_q}, 2'b01);

        // R3 control write makes no edge
        do_reset();
        write_tb(32'h0000_0100);
        write_ctl(4'b0001);
        tick(20);
        chk("R3 no edge from period change", {30'd0, sts_q}, 0);

        // R3 spacing per tap code
        for (int p = 0; p < 4; p++) begin
            do_reset();
            write_ctl(p[3:0]);
            t = 0;
            while (!sts_q[0] && t < 20000) begin tick(1); t++; end
            t1 = t;
            clear_sts(2'b01); t++;
            while (!sts_q[0] && t < 40000) begin tick(1); t++; end
            chk($sformatf("R3 spacing code %0d", p), t - t1, 1 << (tap(p[1:0]) + 1));
        end

        // R5 then R6 steps
        do_reset();
        write_ctl(4'b0011);
        t = 0;
        while (sts_q == 0 && t < 50) begin tick(1); t++; end
        chk("R5 arm only", {29'd0, sts_q, wd_rst_req}, {29'd0, 2'b01, 1'b0});
        t = 0;
        while (sts_q == 2'b01 && t < 50) begin tick(1); t++; end
        chk("R6 fire", {30'd0, sts_q}, 2'b11);

        // R7 enable combinations, status stays set
        write_ctl(4'b0111);
        for (int i = 0; i < 4; i++) begin
            {crit_en, guest_en} = i[1:0];
            tick(1);
            chk("R7 irq combo", {31'd0, wd_irq}, {31'd0, i != 0});
        end
        write_ctl(4'b0011);
        tick(1);
        chk("R7 irq disabled", {31'd0, wd_irq}, 0);

        // R8 escalation and gating
        write_ctl(4'b1011);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin tick(1); cnt += wd_rst_req; end
        chk("R8 reset requested", {31'd0, cnt > 0}, 1);
        write_ctl(4'b0011);
        tick(1);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin tick(1); cnt += wd_rst_req; end
        chk("R8 gated off", cnt, 0);

        // R9 clears coinciding with time-outs
        sts_we = 1; sts_wdata = 2'b11;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin tick(1); cnt += (sts_q != 0); end
        sts_we = 0;
        chk("R9 set survives clear", {31'd0, cnt > 0}, 1);

        // R10 service window
        do_reset();
        write_ctl(4'b0010);
        tick(300);
        clear_sts(2'b11);
        t = 0;
        while (!sts_q[1] && t < 400) begin tick(1); t++; end
        chk("R10 window", {31'd0, t > 128 && t <= 256}, 1);

        // mixed stimulus against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            tb_we  = ($urandom_range(0, 49) == 0);
            tb_wdata = $urandom & 32'h0000_3FFF;
            ctl_we = ($urandom_range(0, 99) == 0);
            ctl_wdata = 4'($urandom);
            sts_we = ($urandom_range(0, 9) == 0);
            sts_wdata = 2'($urandom);
            crit_en = 1'($urandom);
            guest_en = 1'($urandom);
            tick(1);
        end
        tb_we = 0; ctl_we = 0; sts_we = 0;
        tick(2);
        finish_run();
    end
endmodule